// File: doc/BRIEF.md
# Colour Lookup Table with Sequential Byte Loader

This block holds a table of colours indexed by an 8-bit pixel code. Software loads it through a narrow byte-wide port. It has two addresses: a pointer address and a colour-data address. A byte written to the pointer address selects the entry to be loaded. The next three bytes written to the data address supply that entry's red, green and blue parts. The entry is stored in one step, when its third byte arrives. The pointer then moves on by one, so a whole table can be loaded as one long run of data bytes.

On the pixel side, a valid/ready stream carries pixel codes in and resolved 24-bit colours out. The output stage registers each colour, so a colour appears one cycle after its code is accepted. The output holds its value while the consumer applies back-pressure. The input is ready whenever the output register is empty or is being drained in the same cycle. When the bypass pin is high, the table is skipped and a 24-bit direct-colour word given with the code passes through unchanged. This serves the wide-colour display modes.

Top module: `clut_core`

## Requirements
- R1: After reset, `col_valid` is 0, every table entry reads as 24'h000000, the load pointer is 0, and the next data byte is taken as red.
- R2: A write with `wr_sel`=0 (pointer address) sets the load pointer to `wr_data` and restarts the colour sequence, so the next data byte is red.
- R3: Writes with `wr_sel`=1 (data address) are taken in the order red, green, blue. The addressed entry changes only when the blue byte arrives; after red alone or red and green, a lookup still returns the old colour.
- R4: After the blue byte is stored, the load pointer increases by one and wraps from 255 to 0. The following three data bytes fill the next entry.
- R5: A pixel code accepted on the input stream (`pix_valid` and `pix_ready` both 1) yields, one cycle later, `col_valid`=1 and `col_rgb` = that entry, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R6: If `bypass` is 1 when a code is accepted, `col_rgb` equals the `pix_direct` value taken with it and the table is not consulted. The level of `bypass` has no effect on loading the table.
- R7: `pix_ready` is 1 exactly when `col_valid` is 0 or `col_ready` is 1. While `col_valid`=1 and `col_ready`=0, `col_valid` and `col_rgb` stay unchanged.
- R8: When the output is consumed and no new code is accepted in the same cycle, `col_valid` falls to 0 on the next cycle.
- R9: A lookup accepted in the same cycle as a blue byte that stores the same entry returns that entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one write per cycle |
| wr_sel | input | 1 | 0 = pointer address, 1 = colour-data address |
| wr_data | input | 8 | Write byte |
| bypass | input | 1 | 1 = pass direct colour, skip the table |
| pix_valid | input | 1 | Pixel code offered |
| pix_ready | output | 1 | Pixel code accepted when high with pix_valid |
| pix_code | input | 8 | Pixel code (table index) |
| pix_direct | input | 24 | Direct colour used in bypass |
| col_valid | output | 1 | Colour output valid |
| col_ready | input | 1 | Consumer accepts the colour |
| col_rgb | output | 24 | Resolved colour {red, green, blue} |

## Verification
On every cycle, the assertions check the stream rules: output held under back-pressure, the ready rule, one-cycle latency and draining. They also check bypass pass-through, the pointer restart on a pointer write, and the pointer step after each stored blue byte. Only the bench's scenarios can show that table contents are right. These are: a full load of all 256 entries read back in order, partial sequences that must leave an entry untouched, the pointer wrap from 255 to 0, and the lookup that collides with a store.

// File: rtl/clut_pkg.sv
package clut_pkg;
  // Position in the three-byte colour sequence
  typedef enum logic [1:0] {
    C_RED = 2'd0,
    C_GRN = 2'd1,
    C_BLU = 2'd2
  } comp_e;

  // wr_sel decoding
  localparam logic SEL_POINTER = 1'b0;
  localparam logic SEL_DATA    = 1'b1;
endpackage

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [COMP_W-1:0]     wr_data,
  output logic                  store,
  output logic [IDX_W-1:0]      store_idx,
  output logic [3*COMP_W-1:0]   store_rgb,
  output logic [IDX_W-1:0]      ptr,
  output logic [1:0]            phase
);
  comp_e               comp_q;
  logic [IDX_W-1:0]    ptr_q;
  logic [COMP_W-1:0]   red_q, grn_q;

  // Store fires on the blue byte only
  assign store     = wr_en && (wr_sel == SEL_DATA) && (comp_q == C_BLU);
  assign store_idx = ptr_q;
  assign store_rgb = {red_q, grn_q, wr_data};
  assign ptr       = ptr_q;
  assign phase     = comp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      comp_q <= C_RED;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_POINTER) begin
        ptr_q  <= wr_data[IDX_W-1:0];
        comp_q <= C_RED;
      end else begin
        case (comp_q)
          C_RED: begin
            red_q  <= wr_data;
            comp_q <= C_GRN;
          end
          C_GRN: begin
            grn_q  <= wr_data;
            comp_q <= C_BLU;
          end
          C_BLU: begin
            ptr_q  <= ptr_q + 1'b1;
            comp_q <= C_RED;
          end
          default: comp_q <= C_RED;
        endcase
      end
    end
  end
endmodule

// File: rtl/clut_table.sv
module clut_table #(
  parameter int IDX_W = 8,
  parameter int WORD_W = 24,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Read is combinational; the stage after it supplies the register
  assign rdata = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/clut_out_stage.sv
module clut_out_stage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/clut_core.sv
module clut_core #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [COMP_W-1:0] wr_data,
  input  logic              bypass,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [IDX_W-1:0]  pix_code,
  input  logic [RGB_W-1:0]  pix_direct,
  output logic              col_valid,
  input  logic              col_ready,
  output logic [RGB_W-1:0]  col_rgb
);
  logic              store;
  logic [IDX_W-1:0]  store_idx;
  logic [RGB_W-1:0]  store_rgb;
  logic [IDX_W-1:0]  wr_ptr;
  logic [1:0]        wr_phase;
  logic [RGB_W-1:0]  tbl_rgb;
  logic [RGB_W-1:0]  pick_rgb;

  clut_loader #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .store(store), .store_idx(store_idx), .store_rgb(store_rgb),
    .ptr(wr_ptr), .phase(wr_phase)
  );

  clut_table #(.IDX_W(IDX_W), .WORD_W(RGB_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(store), .waddr(store_idx), .wdata(store_rgb),
    .raddr(pix_code), .rdata(tbl_rgb)
  );

  assign pick_rgb = bypass ? pix_direct : tbl_rgb;

  clut_out_stage #(.W(RGB_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(pix_valid), .in_ready(pix_ready), .in_data(pick_rgb),
    .out_valid(col_valid), .out_ready(col_ready), .out_data(col_rgb)
  );
endmodule

// File: rtl/clut_checker.sv
module clut_checker #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  localparam int RGB_W = 3 * COMP_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [COMP_W-1:0] wr_data,
  input logic              bypass,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic [RGB_W-1:0]  pix_direct,
  input logic              col_valid,
  input logic              col_ready,
  input logic [RGB_W-1:0]  col_rgb,
  input logic [IDX_W-1:0]  wr_ptr,
  input logic [1:0]        wr_phase
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready |=> col_valid && $stable(col_rgb)); // R7

  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready |-> !pix_ready); // R7

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> col_valid); // R5

  AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    col_ready && !pix_valid |=> !col_valid); // R8

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && bypass |=> col_rgb == $past(pix_direct)); // R6

  AST_POINTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel |=> wr_phase == 2'd0 && wr_ptr == $past(wr_data[IDX_W-1:0])); // R2

  AST_POINTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && wr_phase == 2'd2 |=>
      wr_phase == 2'd0 && wr_ptr == IDX_W'($past(wr_ptr) + 1'b1)); // R4
endmodule

bind clut_core clut_checker #(.IDX_W(IDX_W), .COMP_W(COMP_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .bypass(bypass), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .pix_direct(pix_direct), .col_valid(col_valid), .col_ready(col_ready),
  .col_rgb(col_rgb), .wr_ptr(wr_ptr), .wr_phase(wr_phase)
);

// File: tb/test_clut_core.sv
`timescale 1ns/1ps
module test_clut_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        bypass = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_code = '0;
  logic [23:0] pix_direct = '0;
  logic        col_valid;
  logic        col_ready = 1'b1;
  logic [23:0] col_rgb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side model of the table and loader
  logic [23:0] model [256];
  logic [7:0]  m_ptr = 8'd0;
  int          m_phase = 0;
  logic [7:0]  m_r, m_g;

  always #2.5 clk = ~clk;

  clut_core i_clut_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .bypass(bypass), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_code(pix_code), .pix_direct(pix_direct), .col_valid(col_valid),
    .col_ready(col_ready), .col_rgb(col_rgb)
  );

  function automatic logic [23:0] pat(int i, int salt);
    logic [7:0] r, g, b;
    r = 8'(i + salt);
    g = 8'(i) ^ 8'hA5 ^ 8'(salt);
    b = 8'(i * 7 + 3 + salt);
    return {r, g, b};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic put_ptr(logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    m_ptr = v; m_phase = 0;
  endtask

  task automatic put_byte(logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_phase == 0) begin m_r = v; m_phase = 1; end
    else if (m_phase == 1) begin m_g = v; m_phase = 2; end
    else begin model[m_ptr] = {m_r, m_g, v}; m_ptr = m_ptr + 8'd1; m_phase = 0; end
  endtask

  task automatic put_rgb(logic [23:0] c);
    put_byte(c[23:16]); put_byte(c[15:8]); put_byte(c[7:0]);
  endtask

  // Accept one code with the output draining; result sampled one cycle later
  task automatic look(logic [7:0] code, logic [23:0] direct, bit byp, output logic [23:0] res);
    @(negedge clk);
    pix_valid = 1'b1; pix_code = code; pix_direct = direct; bypass = byp; col_ready = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0; bypass = 1'b0;
    res = col_rgb;
    chk(col_valid == 1'b1, "R5 valid", 32'(col_valid), 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] got;
    for (int i = 0; i < 256; i++) model[i] = 24'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(col_valid == 1'b0, "R1 col_valid", 32'(col_valid), 32'd0);
    chk(pix_ready == 1'b1, "R7 ready idle", 32'(pix_ready), 32'd1);
    for (int i = 0; i < 256; i += 51) begin
      look(8'(i), 24'hFFFFFF, 1'b0, got);
      chk(got == 24'h0, "R1 entry zero", 32'(got), 32'h0);
    end
    // R1: pointer starts at 0 with red first, no pointer write needed
    put_rgb(24'h123456);
    look(8'd0, 24'h0, 1'b0, got);
    chk(got == 24'h123456, "R1 default pointer", 32'(got), 32'h123456);

    // R4 R5: full load as one run from 0, wrapping around
    put_ptr(8'd0);
    for (int i = 0; i < 256; i++) put_rgb(pat(i, 0));
    for (int i = 0; i < 256; i++) begin
      look(8'(i), 24'h0, 1'b0, got);
      chk(got == model[i] && got == pat(i, 0), "R5 lookup", 32'(got), 32'(pat(i, 0)));
    end
    // R4: the pointer wrapped to 0 after entry 255
    put_rgb(24'hABCDEF);
    look(8'd0, 24'h0, 1'b0, got);
    chk(got == 24'hABCDEF, "R4 wrap to 0", 32'(got), 32'hABCDEF);
    put_ptr(8'd255);
    put_rgb(24'h010203);
    put_rgb(24'h040506);
    look(8'd255, 24'h0, 1'b0, got);
    chk(got == 24'h010203, "R4 entry 255", 32'(got), 32'h010203);
    look(8'd0, 24'h0, 1'b0, got);
    chk(got == 24'h040506, "R4 after wrap", 32'(got), 32'h040506);

    // R3: partial sequences leave the entry alone
    put_ptr(8'd10);
    put_byte(8'h77);
    look(8'd10, 24'h0, 1'b0, got);
    chk(got == pat(10, 0), "R3 after red", 32'(got), 32'(pat(10, 0)));
    put_byte(8'h88);
    look(8'd10, 24'h0, 1'b0, got);
    chk(got == pat(10, 0), "R3 after green", 32'(got), 32'(pat(10, 0)));
    // R2: pointer write restarts at red
    put_ptr(8'd10);
    put_rgb(24'hC0FFEE);
    look(8'd10, 24'h0, 1'b0, got);
    chk(got == 24'hC0FFEE, "R2 restart", 32'(got), 32'hC0FFEE);
    look(8'd11, 24'h0, 1'b0, got);
    chk(got == pat(11, 0), "R2 neighbour untouched", 32'(got), 32'(pat(11, 0)));

    // R6: bypass passes direct colour; bypass level does not affect loading
    for (int i = 0; i < 8; i++) begin
      look(8'(i * 37), pat(i, 91), 1'b1, got);
      chk(got == pat(i, 91), "R6 bypass", 32'(got), 32'(pat(i, 91)));
    end
    put_ptr(8'd20);
    @(negedge clk); bypass = 1'b1;
    put_rgb(24'h5A5A5A);
    @(negedge clk); bypass = 1'b0;
    look(8'd20, 24'h0, 1'b0, got);
    chk(got == 24'h5A5A5A, "R6 load under bypass", 32'(got), 32'h5A5A5A);

    // R7: back-pressure
    @(negedge clk);
    col_ready = 1'b0; pix_valid = 1'b1; pix_code = 8'd20; bypass = 1'b0;
    @(negedge clk);
    pix_code = 8'd10;
    chk(col_valid == 1'b1, "R7 valid", 32'(col_valid), 32'd1);
    chk(pix_ready == 1'b0, "R7 not ready", 32'(pix_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk(col_valid == 1'b1 && col_rgb == 24'h5A5A5A, "R7 held", 32'(col_rgb), 32'h5A5A5A);
    col_ready = 1'b1;
    #0.1;
    chk(pix_ready == 1'b1, "R7 ready on drain", 32'(pix_ready), 32'd1);
    @(negedge clk);
    pix_valid = 1'b0;
    chk(col_valid == 1'b1 && col_rgb == 24'hC0FFEE, "R7 next", 32'(col_rgb), 32'hC0FFEE);
    // R8: drains with no new code
    @(negedge clk);
    chk(col_valid == 1'b0, "R8 drop", 32'(col_valid), 32'd0);

    // R9: lookup colliding with the store of the same entry
    put_ptr(8'd30);
    put_byte(8'h11); put_byte(8'h22);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h33;
    pix_valid = 1'b1; pix_code = 8'd30; col_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pix_valid = 1'b0;
    chk(col_rgb == pat(30, 0), "R9 old value", 32'(col_rgb), 32'(pat(30, 0)));
    look(8'd30, 24'h0, 1'b0, got);
    chk(got == 24'h112233, "R9 stored after", 32'(got), 32'h112233);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule